// File: doc/BRIEF.md
# Floating-Point Timing-Error Replay Controller

This block sits next to a 32-bit single-precision floating-point execute stage. It takes each operation from the issue side and presents it to the datapath. In the cycle the operation executes, in-situ sensors return one timing-error flag per result bit. The controller then decides whether the result can retire or whether the operation has to run again. Replays happen at the same clock frequency: the issue side is stalled for a fixed number of cycles and the held operands are presented again. If an operation keeps failing after a bounded number of replays, the controller raises a fatal pulse and drops it.

Software picks between accurate and approximate operation through a small register file. In accurate mode, any flagged bit forces a replay. In approximate mode, flags on the lowest N fraction bits are ignored, and the result retires with a marker that an uncorrected error was passed on. Flags on the sign and exponent bits always force a replay. The mode and N are copied into a tag when an operation is accepted, so approximate and accurate operations can be interleaved back to back.

Two saturating counters serve as vulnerability metadata. One counts the cycles in which an operation executed. The other counts the cycles that had an error that was not masked. Software can read both, and derive the error percentage from them.

Top module: `fp_terr_ctrl`

## Requirements
- R1: After reset, dp_valid, replay_stall, fatal_err and done_valid are 0 and in_ready is 1. All register reads return 0: the mode is accurate, N is 0 and both counters are 0.
- R2: A write to address 0 sets the approximate-mode bit from data bit 0 and N from data bits 12:8. A value of N above 23 is stored as 23. Reading address 0 returns the stored mode in bit 0 and N in bits 12:8, with every other bit 0.
- R3: A cycle with dp_valid high and an error that is not masked causes a replay, unless the retry limit has been reached. For the following 3 cycles, replay_stall is 1 while dp_valid and in_ready are 0. In the next cycle, dp_valid returns with the same operands and the same tag.
- R4: In approximate mode, flags only on fraction bits below N give done_valid=1 and done_masked_err=1 in the execute cycle, and no stall follows.
- R5: Flags on bits 31:23 (sign and exponent) always cause a replay, in either mode and for any N. So does a flag on a fraction bit at or above N.
- R6: The mode and N used for masking, and dp_approx, are captured when an operation is accepted. A register write while that operation is executing or replaying does not change them.
- R7: An error that is not masked on the fifth execution of one operation (after 4 failed replays) pulses fatal_err instead of replaying. The operation is dropped, and the next cycle has dp_valid=0, replay_stall=0 and in_ready=1.
- R8: Read address 1 returns the number of cycles with dp_valid=1. Read address 2 returns the number of those cycles that had an error that was not masked.
- R9: Both counters stop at their all-ones value (CNT_W bits, 32 by default). A write to address 1 clears both counters to 0 on the next cycle, and the clear takes priority over counting.
- R10: in_ready is 0 during a stall and in an execute cycle that has an error that is not masked. In a clean execute cycle in_ready is 1, so a new operation is accepted on that same edge and executes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Write address: 0 mode/N, 1 clear counters |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | 2 | Read address: 0 mode/N, 1 active count, 2 error count |
| cfg_rd_data | output | 32 | Read data (combinational) |
| in_valid | input | 1 | Issue side offers an operation |
| in_ready | output | 1 | Controller accepts the operation on this edge |
| in_a | input | 32 | Operand A from issue |
| in_b | input | 32 | Operand B from issue |
| dp_valid | output | 1 | Operation executing this cycle |
| dp_a | output | 32 | Operand A to datapath |
| dp_b | output | 32 | Operand B to datapath |
| dp_approx | output | 1 | Tagged mode of the executing operation |
| err_flags | input | 32 | Per-result-bit timing-error flags for the executing operation |
| done_valid | output | 1 | Executing operation retires this cycle |
| done_masked_err | output | 1 | Retiring result carries ignored low-fraction errors |
| replay_stall | output | 1 | Stall before a replay |
| fatal_err | output | 1 | Retry limit exceeded, operation dropped |

## Verification
The assertions check the timing rules on every cycle. While stalled, nothing issues and the operands stay frozen. A stall always lasts exactly three cycles and is followed by a re-execution. Sign and exponent errors never retire. After a fatal pulse, the controller is idle again. A clear empties both counters, the active count never falls without a clear, and the error count never exceeds the active count. Only the bench scenarios can show which flag patterns are masked for a given mode and N. They also show that a mid-flight register write leaves the tag alone, that the fifth failure is the fatal one, that back-to-back issue works, and that the counter values match the exact number of execute and error cycles, including saturation.

// File: rtl/fpte_pkg.sv
`timescale 1ns/1ps
package fpte_pkg;

  typedef enum logic {
    RP_RUN   = 1'b0,
    RP_STALL = 1'b1
  } rp_state_e;

  // Limit a requested mask width to the fraction field width.
  function automatic int unsigned clamp_n(input int unsigned raw, input int unsigned lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // One bit of the ignore mask: fraction bit idx is ignored when approximate and idx < n.
  function automatic logic bit_ignored(input logic apx, input int unsigned idx,
                                       input int unsigned n, input int unsigned frac_w);
    return apx && (idx < frac_w) && (idx < n);
  endfunction

endpackage

// File: rtl/fpte_cfg.sv
`timescale 1ns/1ps
module fpte_cfg #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23,
  parameter int NW     = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  act_cnt,
  input  logic [CNT_W-1:0]  err_cnt,
  output logic              mode_apx,
  output logic [NW-1:0]     mode_n,
  output logic              cnt_clr
);
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_ACT  = 2'd1;
  localparam logic [1:0] A_ERR  = 2'd2;
  localparam int         N_LSB  = 8;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[DATA_W-1:N_LSB+NW], wr_data[N_LSB-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_apx <= 1'b0;
      mode_n   <= '0;
    end else if (wr_en && wr_addr == A_MODE) begin
      mode_apx <= wr_data[0];
      mode_n   <= NW'(fpte_pkg::clamp_n(int'(wr_data[N_LSB +: NW]), FRAC_W));
    end
  end

  assign cnt_clr = wr_en && (wr_addr == A_ACT);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE: begin
        rd_data[0]          = mode_apx;
        rd_data[N_LSB +: NW] = mode_n;
      end
      A_ACT:   rd_data = DATA_W'(act_cnt);
      A_ERR:   rd_data = DATA_W'(err_cnt);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fpte_mask.sv
`timescale 1ns/1ps
module fpte_mask #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23,
  parameter int NW     = 5
) (
  input  logic [DATA_W-1:0] flags,
  input  logic              apx,
  input  logic [NW-1:0]     n,
  output logic              any_unmasked,
  output logic              any_flag
);
  logic [DATA_W-1:0] ignore;
  logic [DATA_W-1:0] kept;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g < FRAC_W) begin : g_frac
      assign ignore[g] = fpte_pkg::bit_ignored(apx, g, int'(n), FRAC_W);
    end else begin : g_protected
      assign ignore[g] = 1'b0;
    end
  end

  assign kept         = flags & ~ignore;
  assign any_unmasked = |kept;
  assign any_flag     = |flags;
endmodule

// File: rtl/fpte_replay.sv
`timescale 1ns/1ps
module fpte_replay #(
  parameter int DATA_W    = 32,
  parameter int NW        = 5,
  parameter int STALL_CYC = 3,
  parameter int MAX_RETRY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              in_ready,
  input  logic              cur_apx,
  input  logic [NW-1:0]     cur_n,
  input  logic              unm_err,
  output logic              dp_valid,
  output logic [DATA_W-1:0] dp_a,
  output logic [DATA_W-1:0] dp_b,
  output logic              dp_apx,
  output logic [NW-1:0]     dp_n,
  output logic              done_valid,
  output logic              replay_stall,
  output logic              fatal
);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam int SW = $clog2(STALL_CYC + 1);

  fpte_pkg::rp_state_e st;
  logic [RW-1:0] retry;
  logic [SW-1:0] stall_cnt;
  logic          accept;
  logic          at_limit;
  logic          bad_exec;

  assign bad_exec     = dp_valid && unm_err;
  assign at_limit     = (retry == RW'(MAX_RETRY));
  assign in_ready     = (st == fpte_pkg::RP_RUN) && !bad_exec;
  assign accept       = in_valid && in_ready;
  assign done_valid   = dp_valid && !unm_err;
  assign fatal        = bad_exec && at_limit;
  assign replay_stall = (st == fpte_pkg::RP_STALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= fpte_pkg::RP_RUN;
      retry     <= '0;
      stall_cnt <= '0;
      dp_valid  <= 1'b0;
      dp_a      <= '0;
      dp_b      <= '0;
      dp_apx    <= 1'b0;
      dp_n      <= '0;
    end else begin
      case (st)
        fpte_pkg::RP_RUN: begin
          if (bad_exec) begin
            dp_valid <= 1'b0;
            if (at_limit) begin
              retry <= '0;
            end else begin
              retry     <= retry + 1'b1;
              stall_cnt <= '0;
              st        <= fpte_pkg::RP_STALL;
            end
          end else if (accept) begin
            dp_valid <= 1'b1;
            dp_a     <= in_a;
            dp_b     <= in_b;
            dp_apx   <= cur_apx;
            dp_n     <= cur_n;
            retry    <= '0;
          end else begin
            dp_valid <= 1'b0;
          end
        end
        fpte_pkg::RP_STALL: begin
          if (stall_cnt == SW'(STALL_CYC - 1)) begin
            st       <= fpte_pkg::RP_RUN;
            dp_valid <= 1'b1;
          end else begin
            stall_cnt <= stall_cnt + 1'b1;
          end
        end
        default: st <= fpte_pkg::RP_RUN;
      endcase
    end
  end
endmodule

// File: rtl/fpte_metric.sv
`timescale 1ns/1ps
module fpte_metric #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic             err,
  output logic [CNT_W-1:0] act_cnt,
  output logic [CNT_W-1:0] err_cnt
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic en);
    return (en && v != {CNT_W{1'b1}}) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      act_cnt <= '0;
      err_cnt <= '0;
    end else begin
      act_cnt <= sat_inc(act_cnt, active);
      err_cnt <= sat_inc(err_cnt, active && err);
    end
  end
endmodule

// File: rtl/fp_terr_ctrl.sv
`timescale 1ns/1ps
module fp_terr_ctrl #(
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 23,
  parameter int STALL_CYC = 3,
  parameter int MAX_RETRY = 4,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic [1:0]        cfg_rd_addr,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              dp_valid,
  output logic [DATA_W-1:0] dp_a,
  output logic [DATA_W-1:0] dp_b,
  output logic              dp_approx,
  input  logic [DATA_W-1:0] err_flags,
  output logic              done_valid,
  output logic              done_masked_err,
  output logic              replay_stall,
  output logic              fatal_err
);
  localparam int NW = $clog2(FRAC_W + 1);

  logic             mode_apx;
  logic [NW-1:0]    mode_n;
  logic [NW-1:0]    dp_n;
  logic             cnt_clr;
  logic             unm_err;
  logic             any_flag;
  logic [CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] err_cnt;

  fpte_cfg #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .NW(NW), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
    .act_cnt(act_cnt), .err_cnt(err_cnt),
    .mode_apx(mode_apx), .mode_n(mode_n), .cnt_clr(cnt_clr)
  );

  fpte_mask #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .NW(NW)) u_mask (
    .flags(err_flags), .apx(dp_approx), .n(dp_n),
    .any_unmasked(unm_err), .any_flag(any_flag)
  );

  fpte_replay #(.DATA_W(DATA_W), .NW(NW), .STALL_CYC(STALL_CYC), .MAX_RETRY(MAX_RETRY)) u_replay (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
    .cur_apx(mode_apx), .cur_n(mode_n), .unm_err(unm_err),
    .dp_valid(dp_valid), .dp_a(dp_a), .dp_b(dp_b), .dp_apx(dp_approx), .dp_n(dp_n),
    .done_valid(done_valid), .replay_stall(replay_stall), .fatal(fatal_err)
  );

  fpte_metric #(.CNT_W(CNT_W)) u_metric (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .active(dp_valid), .err(unm_err),
    .act_cnt(act_cnt), .err_cnt(err_cnt)
  );

  assign done_masked_err = done_valid && any_flag;
endmodule

// File: rtl/fpte_chk.sv
`timescale 1ns/1ps
module fpte_chk #(
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 23,
  parameter int STALL_CYC = 3,
  parameter int CNT_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              dp_valid,
  input logic [DATA_W-1:0] dp_a,
  input logic [DATA_W-1:0] dp_b,
  input logic              dp_approx,
  input logic [DATA_W-1:0] err_flags,
  input logic              done_valid,
  input logic              done_masked_err,
  input logic              replay_stall,
  input logic              fatal_err,
  input logic              unm_err,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  act_cnt,
  input logic [CNT_W-1:0]  err_cnt
);
  localparam int RUNW = $clog2(STALL_CYC + 2);
  logic [RUNW-1:0] stall_run;

  always_ff @(posedge clk) begin
    if (!rst_n)            stall_run <= '0;
    else if (replay_stall) stall_run <= stall_run + 1'b1;
    else                   stall_run <= '0;
  end

  AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    replay_stall |-> (!dp_valid && !in_ready)); // R3
  AST_STALL_HOLDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    replay_stall |-> ($stable(dp_a) && $stable(dp_b) && $stable(dp_approx))); // R6
  AST_ERR_STARTS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && unm_err && !fatal_err) |=> replay_stall); // R3
  AST_STALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    replay_stall |-> (stall_run < RUNW'(STALL_CYC))); // R3
  AST_STALL_THEN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(replay_stall) |-> (dp_valid && stall_run == RUNW'(STALL_CYC))); // R3
  AST_SIGN_EXP_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && |err_flags[DATA_W-1:FRAC_W]) |-> !done_valid); // R5
  AST_MASKED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_masked_err |=> !replay_stall); // R4
  AST_FATAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> (!dp_valid && !replay_stall && in_ready)); // R7
  AST_ACT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (act_cnt >= $past(act_cnt))); // R8
  AST_ERR_NOT_ABOVE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= act_cnt); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (act_cnt == '0 && err_cnt == '0)); // R9
endmodule

bind fp_terr_ctrl fpte_chk #(
  .DATA_W(DATA_W), .FRAC_W(FRAC_W), .STALL_CYC(STALL_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .dp_valid(dp_valid),
  .dp_a(dp_a), .dp_b(dp_b), .dp_approx(dp_approx), .err_flags(err_flags),
  .done_valid(done_valid), .done_masked_err(done_masked_err),
  .replay_stall(replay_stall), .fatal_err(fatal_err), .unm_err(unm_err),
  .cnt_clr(cnt_clr), .act_cnt(act_cnt), .err_cnt(err_cnt)
);

// File: tb/fp_terr_ctrl_tb.sv
`timescale 1ns/1ps
module fp_terr_ctrl_tb;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  cfg_rd_addr = '0;
  logic [31:0] cfg_rd_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic        dp_valid;
  logic [31:0] dp_a, dp_b;
  logic        dp_approx;
  logic [31:0] err_flags = '0;
  logic        done_valid, done_masked_err, replay_stall, fatal_err;

  int n_checks = 0;
  int n_errs   = 0;
  int exp_act  = 0;
  int exp_err  = 0;
  bit cur_apx  = 0;
  int cur_n    = 0;
  logic [31:0] fseq [5];
  logic [31:0] rd;

  always #4 clk = ~clk;

  fp_terr_ctrl #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .dp_valid(dp_valid), .dp_a(dp_a), .dp_b(dp_b), .dp_approx(dp_approx),
    .err_flags(err_flags), .done_valid(done_valid), .done_masked_err(done_masked_err),
    .replay_stall(replay_stall), .fatal_err(fatal_err)
  );

  function automatic bit ref_unmasked(input logic [31:0] f, input bit apx, input int n);
    for (int i = 0; i < 32; i++)
      if (f[i] && !(apx && i < 23 && i < n)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int ref_clamp(input int raw);
    return (raw > 23) ? 23 : raw;
  endfunction

  function automatic int ref_sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] addr, input logic [31:0] data);
    cfg_wr_en = 1'b1; cfg_wr_addr = addr; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] addr, output logic [31:0] data);
    cfg_rd_addr = addr;
    #1;
    data = cfg_rd_data;
  endtask

  task automatic set_mode(input bit apx, input int raw_n);
    do_write(2'd0, {19'd0, 5'(raw_n), 7'd0, apx});
    cur_apx = apx;
    cur_n   = ref_clamp(raw_n);
  endtask

  task automatic clear_counters();
    do_write(2'd1, 32'd0);
    exp_act = 0; exp_err = 0;
  endtask

  task automatic check_counters(input string req);
    do_read(2'd1, rd); chk(req, "active count", rd, ref_sat(exp_act));
    do_read(2'd2, rd); chk(req, "error count", rd, ref_sat(exp_err));
  endtask

  // Issues one operation and walks it through up to five executions using fseq.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b);
    bit apx = cur_apx;
    int n   = cur_n;
    bit finished = 0;
    chk("R10", "in_ready idle", in_ready, 1);
    in_valid = 1'b1; in_a = a; in_b = b; err_flags = '0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int att = 0; att < 5 && !finished; att++) begin
      err_flags = fseq[att];
      #1;
      chk("R3", "dp_valid", dp_valid, 1);
      chk("R3", "dp_a", dp_a, a);
      chk("R3", "dp_b", dp_b, b);
      chk("R6", "dp_approx", dp_approx, apx);
      exp_act++;
      if (!ref_unmasked(fseq[att], apx, n)) begin
        chk("R4", "done_valid", done_valid, 1);
        chk("R4", "done_masked_err", done_masked_err, (fseq[att] != 0));
        @(negedge clk); err_flags = '0; #1;
        chk("R4", "no stall after retire", replay_stall, 0);
        finished = 1;
      end else begin
        exp_err++;
        chk("R5", "no retire on error", done_valid, 0);
        chk("R10", "in_ready on error", in_ready, 0);
        if (att == 4) begin
          chk("R7", "fatal_err", fatal_err, 1);
          @(negedge clk); err_flags = '0; #1;
          chk("R7", "idle after fatal", {dp_valid, replay_stall, in_ready}, 3'b001);
          finished = 1;
        end else begin
          chk("R7", "no early fatal", fatal_err, 0);
          @(negedge clk); err_flags = '0;
          for (int k = 0; k < 3; k++) begin
            #1;
            chk("R3", "stall cycle", {replay_stall, dp_valid, in_ready}, 3'b100);
            @(negedge clk);
          end
        end
      end
    end
  endtask

  function automatic logic [31:0] rand_flags(input bit apx, input int n);
    int cls = $urandom % 4;
    case (cls)
      0: return 32'd0;
      1: return 32'd1 << ($urandom % ((n > 0) ? n : 1));
      2: return 32'd1 << (23 + ($urandom % 9));
      default: return $urandom & $urandom & $urandom;
    endcase
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    n_errs++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "dp_valid", dp_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "replay_stall", replay_stall, 0);
    chk("R1", "fatal/done", {fatal_err, done_valid}, 0);
    for (int a = 0; a < 3; a++) begin
      do_read(2'(a), rd); chk("R1", "register reset", rd, 0);
    end
    @(negedge clk);

    // R2 clamp and readback
    set_mode(1, 31);
    do_read(2'd0, rd); chk("R2", "N clamped to 23", rd, 32'h0000_1701);
    set_mode(1, 20);
    do_read(2'd0, rd); chk("R2", "N=20 readback", rd, 32'h0000_1401);
    clear_counters();

    // R4 low fraction error passed on
    fseq = '{32'h0008_0000, 0, 0, 0, 0};
    run_op(32'h3F80_0000, 32'h4000_0000);

    // R5 exponent, sign and unmasked fraction bits replay in approximate mode
    fseq = '{32'h0080_0000, 32'h8000_0000, 32'h0010_0000, 32'h0000_0000, 0};
    run_op(32'h1234_5678, 32'h9ABC_DEF0);

    // R10 back-to-back issue
    in_valid = 1'b1; in_a = 32'hAAAA_0001; in_b = 32'h5555_0001;
    @(negedge clk);
    in_a = 32'hAAAA_0002; in_b = 32'h5555_0002; err_flags = '0; #1;
    chk("R10", "in_ready on clean execute", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0; #1;
    chk("R10", "second op executes next cycle", dp_a, 32'hAAAA_0002);
    chk("R10", "second op valid", dp_valid, 1);
    exp_act += 2;
    @(negedge clk);

    // R6 register write during a replay does not retag the operation
    in_valid = 1'b1; in_a = 32'hCAFE_0000; in_b = 32'h0;
    @(negedge clk);
    in_valid = 1'b0; err_flags = 32'h0200_0000; #1;
    chk("R6", "approx tag", dp_approx, 1);
    @(negedge clk);
    err_flags = '0;
    cfg_wr_en = 1'b1; cfg_wr_addr = 2'd0; cfg_wr_data = 32'h0;
    @(negedge clk);
    cfg_wr_en = 1'b0; cur_apx = 0; cur_n = 0;
    @(negedge clk);
    @(negedge clk);
    err_flags = 32'h0000_0020; #1;
    chk("R6", "replay keeps approx tag", dp_approx, 1);
    chk("R6", "old N still masks bit 5", {done_valid, done_masked_err}, 2'b11);
    exp_act += 2; exp_err += 1;
    @(negedge clk);
    err_flags = '0;
    do_read(2'd0, rd); chk("R6", "write took effect", rd, 0);
    fseq = '{32'h0000_0020, 0, 0, 0, 0};
    run_op(32'hCAFE_0001, 32'h1);

    // R7 fatal after four failed replays (accurate mode)
    fseq = '{32'h1, 32'h1, 32'h1, 32'h1, 32'h1};
    run_op(32'hDEAD_BEEF, 32'h0BAD_F00D);

    // R8 exact counts so far
    check_counters("R8");

    // Random phase, then R9 saturation and clear
    clear_counters();
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 3 == 0) set_mode(1'($urandom % 2), int'($urandom % 32));
      for (int k = 0; k < 5; k++) fseq[k] = rand_flags(cur_apx, cur_n);
      run_op($urandom, $urandom);
    end
    check_counters("R9");
    clear_counters();
    check_counters("R9");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule